// File: doc/BRIEF.md
# Receive Word Queue with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel digital input port until a host or DMA engine drains them through a single data register at a fixed address. Incoming words are stored only while the receive-enable control bit is set. Words come out of the data register in the same order they arrived.

A status word reports four occupancy conditions as active-high "not" flags. Two of them are derived from thresholds that software loads through one packed register. Two sticky error bits record a write lost to a full queue and a read of an empty queue. Software clears each error bit by writing 1 to its position in the status register. Control bits give a queue-only flush and a flush of the whole block. Read-only registers report the queue depth and the current fill level. Everything runs on one clock with a synchronous active-high reset.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the queue is empty, receive is disabled, the thresholds hold their parameter defaults, and the status register reads not-empty at bit 12, not-almost-empty at bit 13, not-almost-full at bit 14, not-full at bit 15, underrun at bit 22 and overrun at bit 23. With the default depth of 16, this gives the value 0x0000C000.
- R2: Register select values are: 0 control, 1 status, 2 thresholds, 3 size, 4 level, 5 data. The control register holds receive-enable at bit 5, and control reads return only that bit.
- R3: A word on the input port with in_valid high is stored only while receive-enable is 1. Words are read back from the data register in arrival order, and each data read with reg_rd removes one word.
- R4: The level register returns the current number of stored words. The size register returns DEPTH in bits 19:0.
- R5: The threshold register holds the almost-empty level in bits 15:0 and the almost-full level in bits 23:16. Not-almost-empty is 0 exactly when the level is at or below the almost-empty value.
- R6: Not-almost-full is 0 exactly when the level is at or above DEPTH minus the almost-full value. That bound is treated as 0 when the almost-full value is DEPTH or more.
- R7: An input word that arrives while the queue is full is dropped, and it sets the sticky overrun bit (status bit 23). The stored contents stay unchanged.
- R8: A data read while the queue is empty sets the sticky underrun bit (status bit 22). It returns the last word successfully read and changes nothing else.
- R9: Writing 1 to status bit 22 or 23 clears that error bit. Writing 0 leaves it unchanged. A new error in the same cycle wins over the clear.
- R10: Writing control bit 2 empties the queue. It keeps the thresholds and the error bits, and receive-enable takes bit 5 of the same write.
- R11: Writing control bit 0 returns the whole block to its reset state of R1, whatever the other bits of that write hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input port word strobe |
| in_data | input | 32 | Input port word |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data register) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench fills the queue across both threshold boundaries, one word at a time, because an off-by-one in either comparison would flip a flag one word early or late. It pushes into a full queue, checks that the extra word never appears on drain, and reads the empty queue to confirm that the previous word is repeated rather than stale memory. It also writes 0 and then single bits to the status register. A write-1-to-clear implemented as a plain write would wipe both error flags, and one that ignores the data would clear them together. The flush paths are checked separately: the queue-only flush must keep the thresholds and error bits, and the full block reset must restore every default.

// File: rtl/rx_word_fifo_pkg.sv
package rx_word_fifo_pkg;

    localparam int DWIDTH = 32;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_THRESH = 3'd2,
        SEL_SIZE   = 3'd3,
        SEL_LEVEL  = 3'd4,
        SEL_DATA   = 3'd5
    } reg_sel_e;

    localparam int CTL_BLOCK_RST = 0;
    localparam int CTL_QUEUE_RST = 2;
    localparam int CTL_RX_EN     = 5;

    localparam int ST_FLAG_LSB = 12;
    localparam int ST_UNDERRUN = 22;
    localparam int ST_OVERRUN  = 23;

    typedef struct packed {
        logic not_full;
        logic not_almost_full;
        logic not_almost_empty;
        logic not_empty;
    } occ_flags_t;

    typedef struct packed {
        logic overrun;
        logic underrun;
    } err_flags_t;

    function automatic logic [DWIDTH-1:0] pack_status(occ_flags_t f, err_flags_t e);
        logic [DWIDTH-1:0] w;
        w = '0;
        w[ST_FLAG_LSB +: 4] = f;
        w[ST_UNDERRUN]      = e.underrun;
        w[ST_OVERRUN]       = e.overrun;
        return w;
    endfunction

endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CFULL);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CFULL);
    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        full && !pop && !clear |=> full);
    a_r3_push_grows: assert property (@(posedge clk) disable iff (rst)
        push && !full && !pop && !clear |=> count == $past(count) + 1'b1);
    a_r8_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
        empty && !push && !clear |=> empty);
endmodule

// File: rtl/rxw_levels.sv
module rxw_levels
    import rx_word_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [15:0]   ae_lvl,
    input  logic [7:0]    af_lvl,
    output occ_flags_t    flags
);
    int unsigned fill, af_bound;

    always_comb begin
        fill     = 32'(count);
        af_bound = (32'(af_lvl) >= DEPTH) ? 0 : DEPTH - 32'(af_lvl);
        flags.not_empty        = (fill != 0);
        flags.not_almost_empty = (fill > 32'(ae_lvl));
        flags.not_almost_full  = (fill < af_bound);
        flags.not_full         = (fill < DEPTH);
    end
endmodule

// File: rtl/rxw_errors.sv
module rxw_errors
    import rx_word_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_ovr,
    input  logic       set_unr,
    input  logic       clr_ovr,
    input  logic       clr_unr,
    output err_flags_t errs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            errs <= '0;
        end else begin
            errs.overrun  <= set_ovr || (errs.overrun && !clr_ovr);
            errs.underrun <= set_unr || (errs.underrun && !clr_unr);
        end
    end

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        errs.overrun && !clr_ovr |=> errs.overrun);
    a_r9_unr_sticky: assert property (@(posedge clk) disable iff (rst)
        errs.underrun && !clr_unr |=> errs.underrun);
    a_r9_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        clr_ovr && !set_ovr |=> !errs.overrun);
    a_r7_ovr_set: assert property (@(posedge clk) disable iff (rst)
        set_ovr |=> errs.overrun);
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import rx_word_fifo_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter logic [15:0] AE_DEFAULT = 16'd2,
    parameter logic [7:0]  AF_DEFAULT = 8'd2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic              ctrl_wr, stat_wr, thr_wr;
    logic              soft_rst, q_clear;
    logic              rx_en;
    logic [15:0]       ae_lvl;
    logic [7:0]        af_lvl;
    logic [DWIDTH-1:0] head, last_word;
    logic [CW-1:0]     count;
    logic              empty, full, push, pop;
    occ_flags_t        occ;
    err_flags_t        errs;

    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign stat_wr  = reg_wr && (reg_sel == SEL_STATUS);
    assign thr_wr   = reg_wr && (reg_sel == SEL_THRESH);
    assign soft_rst = rst || (ctrl_wr && reg_wdata[CTL_BLOCK_RST]);
    assign q_clear  = ctrl_wr && reg_wdata[CTL_QUEUE_RST];
    assign push     = in_valid && rx_en;
    assign pop      = reg_rd && (reg_sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            rx_en     <= 1'b0;
            ae_lvl    <= AE_DEFAULT;
            af_lvl    <= AF_DEFAULT;
            last_word <= '0;
        end else begin
            if (ctrl_wr) rx_en <= reg_wdata[CTL_RX_EN];
            if (thr_wr) begin
                ae_lvl <= reg_wdata[15:0];
                af_lvl <= reg_wdata[23:16];
            end
            if (pop && !empty) last_word <= head;
        end
    end

    rxw_store #(.DEPTH(DEPTH), .WIDTH(DWIDTH)) store_i (
        .clk(clk), .rst(soft_rst), .clear(q_clear),
        .push(push), .pop(pop), .wdata(in_data),
        .head(head), .count(count), .empty(empty), .full(full)
    );

    rxw_levels #(.DEPTH(DEPTH)) levels_i (
        .count(count), .ae_lvl(ae_lvl), .af_lvl(af_lvl), .flags(occ)
    );

    rxw_errors errors_i (
        .clk(clk), .rst(soft_rst),
        .set_ovr(push && full && !q_clear),
        .set_unr(pop && empty),
        .clr_ovr(stat_wr && reg_wdata[ST_OVERRUN]),
        .clr_unr(stat_wr && reg_wdata[ST_UNDERRUN]),
        .errs(errs)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL:   reg_rdata[CTL_RX_EN] = rx_en;
            SEL_STATUS: reg_rdata = pack_status(occ, errs);
            SEL_THRESH: reg_rdata = {8'h00, af_lvl, ae_lvl};
            SEL_SIZE:   reg_rdata[19:0] = 20'(DEPTH);
            SEL_LEVEL:  reg_rdata = 32'(count);
            SEL_DATA:   reg_rdata = empty ? last_word : head;
            default:    reg_rdata = '0;
        endcase
    end

    a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (soft_rst)
        !rx_en && !pop && !q_clear |=> count == $past(count));
    a_r5_empty_is_almost_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !occ.not_almost_empty);
    a_r6_full_is_almost_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !occ.not_almost_full);
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        q_clear |=> empty);
    a_r11_block_reset: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !rx_en && empty && errs == '0);
endmodule

// File: tb/rx_word_fifo_tb_top.sv
module rx_word_fifo_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    logic        m_en = 1'b0;
    int          m_ae = 2, m_af = 2;
    logic        m_ovr = 1'b0, m_unr = 1'b0;
    logic [31:0] m_last = '0;

    always #2 clk = ~clk;

    rx_word_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        int n, afb;
        logic [31:0] w;
        n = exp_q.size();
        afb = (m_af >= DEPTH) ? 0 : DEPTH - m_af;
        w = '0;
        w[12] = n != 0;
        w[13] = n > m_ae;
        w[14] = n < afb;
        w[15] = n < DEPTH;
        w[22] = m_unr;
        w[23] = m_ovr;
        return w;
    endfunction

    task automatic reg_write(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_peek(logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic push_word(logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        if (m_en) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(d);
            else m_ovr = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor side of the scoreboard: pop expected word and compare the data read
    task automatic pop_check(string req);
        logic [31:0] got, exp;
        @(negedge clk);
        reg_sel = 3'd5; reg_rd = 1'b1;
        #1 got = reg_rdata;
        if (exp_q.size() == 0) begin
            exp = m_last; m_unr = 1'b1;
        end else begin
            exp = exp_q.pop_front(); m_last = exp;
        end
        check(req, got, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic check_status(string req);
        logic [31:0] v;
        reg_peek(3'd1, v);
        check(req, v, exp_status());
    endtask

    task automatic check_level(string req);
        logic [31:0] v;
        reg_peek(3'd4, v);
        check(req, v, 32'(exp_q.size()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_peek(3'd1, v); check("R1 status", v, 32'h0000C000);
        reg_peek(3'd0, v); check("R2 ctrl", v, 32'h0);
        reg_peek(3'd2, v); check("R5 thresh default", v, 32'h00020002);
        reg_peek(3'd3, v); check("R4 size", v, 32'(DEPTH));
        check_level("R4 level reset");

        // R3 disabled input ignored
        push_word(32'hDEAD0001);
        check_level("R3 disabled ignored");

        // R2 enable
        reg_write(3'd0, 32'h20); m_en = 1'b1;
        reg_peek(3'd0, v); check("R2 ctrl en", v, 32'h20);

        for (int i = 0; i < 5; i++) push_word(32'hA000_0000 + i);
        check_level("R4 level five");
        check_status("R5 status five");
        for (int i = 0; i < 5; i++) pop_check("R3 order");

        // R5/R6 thresholds: ae=3, af=4 -> almost full at >=12
        reg_write(3'd2, 32'h0004_0003); m_ae = 3; m_af = 4;
        reg_peek(3'd2, v); check("R5 thresh rb", v, 32'h0004_0003);
        for (int i = 0; i < DEPTH; i++) begin
            push_word(32'hB000_0000 + i);
            if (i >= 2 && i <= 3) check_status("R5 ae boundary");
            if (i >= 10 && i <= 11) check_status("R6 af boundary");
        end
        check_status("R7 full status");

        // R7 overrun
        push_word(32'hBAD0_BAD0);
        check_status("R7 overrun set");
        check_level("R7 level kept");
        for (int i = 0; i < DEPTH; i++) pop_check("R7 drain");

        // R8 underrun
        pop_check("R8 empty read last");
        check_status("R8 underrun set");

        // R9 write-1-to-clear
        reg_write(3'd1, 32'h0);
        check_status("R9 zero write keeps");
        reg_write(3'd1, 32'h0080_0000); m_ovr = 1'b0;
        check_status("R9 clear ovr only");
        reg_write(3'd1, 32'h0040_0000); m_unr = 1'b0;
        check_status("R9 clear unr");

        // R6 af value beyond depth -> always almost full
        reg_write(3'd2, 32'h0020_0003); m_af = 32;
        check_status("R6 af saturate");

        // R10 queue flush keeps thresholds and errors
        pop_check("R8 make underrun");
        for (int i = 0; i < 4; i++) push_word(32'hC000_0000 + i);
        reg_write(3'd0, 32'h24); exp_q.delete();
        check_level("R10 flushed");
        check_status("R10 errors kept");
        reg_peek(3'd2, v); check("R10 thresh kept", v, 32'h0020_0003);
        push_word(32'hC0DE_0001);
        pop_check("R10 enable kept");

        // R11 block reset
        push_word(32'hC0DE_0002);
        reg_write(3'd0, 32'h25);
        exp_q.delete(); m_en = 1'b0; m_ae = 2; m_af = 2; m_ovr = 1'b0; m_unr = 1'b0;
        reg_peek(3'd1, v); check("R11 status", v, 32'h0000C000);
        reg_peek(3'd0, v); check("R11 ctrl", v, 32'h0);
        reg_peek(3'd2, v); check("R11 thresh", v, 32'h00020002);
        check_level("R11 level");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule